// File: doc/BRIEF.md
# Raster-Op Shift-Merge Datapath

This block is the word-wide pixel datapath of a one-bit-per-pixel frame buffer. It sits between a blit or host engine and the image memory. For every word handed to it, the block chooses a source: constant ones, a replicated single pixel, or the plane word itself. In block-transfer mode it realigns that plane word by funnel-shifting it against the word read just before. It then combines the source with the current destination word through one of sixteen Boolean raster functions. Finally it protects the bits the write-enable mask marks as locked. The result and a per-bit write strobe leave through a single registered output stage.

Words arrive on a valid/ready handshake and leave on another. A word can be flagged as a priming read. Such a word only loads the previous-word register, which the funnel shifter needs at the start of a misaligned line, and it produces no output. The output stage is a two-state machine. `PS_IDLE` means no word is held. `PS_HOLD` means a merged word waits for the consumer. `PS_IDLE -> PS_HOLD` happens on a non-priming transfer. `PS_HOLD -> PS_IDLE` happens when the consumer takes the word and no new word arrives. `PS_HOLD -> PS_HOLD` happens on a stall, or when a consumed word is replaced in the same cycle. `PS_IDLE -> PS_IDLE` happens otherwise.

Top module: `rop_shift_merge`

## Requirements
- R1: After a synchronous reset `out_valid` is 0 and the previous-word register is 0, so the first block-transfer word shifts in zeros from above.
- R2: The 4-bit raster code selects the result per bit as follows. 0 gives 0. 1 gives S&D. 2 gives S&~D. 3 gives S. 4 gives ~S&D. 5 gives D. 6 gives S^D. 7 gives S|D. 8 gives ~(S|D). 9 gives ~(S^D). A gives ~D. B gives S|~D. C gives ~S. D gives ~S|D. E gives ~(S&D). F gives 1.
- R3: The raster code is taken from bits 3:0 of `in_rop`; bits 15:4 have no effect on the result.
- R4: When `in_rop_en` is 0 the raster result equals the selected source, whatever the code.
- R5: `in_src_sel` 00 makes the source all ones. 01 replicates bit 0 of `in_src` over all 16 bits. 11 (and 10) uses the plane word.
- R6: When `in_mode_shift[7:5]` is 100 (block transfer), the plane word is bits 15:0 of {previous word, `in_src`} shifted right by `in_mode_shift[3:0]`; bit 4 of the shift field is ignored.
- R7: In every other mode (110, 010 vector, 111 normal, and the rest) the plane word is `in_src` unshifted.
- R8: Every accepted word, primed or not and in any mode, loads `in_src` into the previous-word register.
- R9: An accepted word with `in_prime` set produces no output word.
- R10: A bit whose `in_wmask` bit is 1 takes the destination bit; a bit whose mask bit is 0 takes the raster result; `out_strobe` is the inverse of the mask.
- R11: Output appears one cycle after acceptance. `in_ready` is 1 when no word is held or `out_ready` is 1. A held word stays stable while `out_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_prime | input | 1 | Priming read: load previous word only |
| in_src | input | 16 | Source word read from memory |
| in_dst | input | 16 | Current destination word |
| in_rop | input | 16 | Raster-op register, four 4-bit codes |
| in_mode_shift | input | 8 | Mode in bits 7:5, shift amount in bits 4:0 |
| in_src_sel | input | 2 | Source select |
| in_rop_en | input | 1 | Raster function enable |
| in_wmask | input | 16 | Write mask, 1 = bit protected |
| out_valid | output | 1 | Merged word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 16 | Merged word |
| out_strobe | output | 16 | Per-bit write strobe |

## Verification
The hardest state to reach is the previous-word register holding a word that never became output. That happens after a priming read, or after a normal-mode word, followed by a block-transfer word whose shift reaches into that register. A stall at the same time makes it harder still. The stimulus primes with a known word and then sends block-transfer words with shifts of 0, 8, 12 and 24, expecting results by value. A long random run then mixes priming reads, modes, shifts and input gaps with a randomly stalling consumer. A behavioural model tracks the previous word and the held output every cycle.

// File: rtl/rop_pkg.sv
package rop_pkg;
    localparam logic [2:0] MODE_BLIT = 3'b100;
    localparam logic [2:0] MODE_VEC  = 3'b010;
    localparam logic [2:0] MODE_NORM = 3'b111;

    typedef enum logic [1:0] {
        SRC_ONES  = 2'b00,
        SRC_PIX   = 2'b01,
        SRC_ALT   = 2'b10,
        SRC_PLANE = 2'b11
    } src_sel_t;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_HOLD = 1'b1
    } pipe_state_t;
endpackage

// File: rtl/rop_src_path.sv
module rop_src_path
    import rop_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int AMT_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] prev_word,
    input  logic [WORD_W-1:0] cur_word,
    input  logic              blit_en,
    input  logic [AMT_W-1:0]  amount,
    input  logic [1:0]        sel,
    output logic [WORD_W-1:0] src_word
);
    logic [2*WORD_W-1:0] joined;
    logic [WORD_W-1:0]   aligned;

    always_comb begin
        joined  = {prev_word, cur_word} >> amount;
        aligned = blit_en ? joined[WORD_W-1:0] : cur_word;
    end

    always_comb begin
        unique case (src_sel_t'(sel))
            SRC_ONES:  src_word = '1;
            SRC_PIX:   src_word = {WORD_W{cur_word[0]}};
            SRC_ALT,
            SRC_PLANE: src_word = aligned;
            default:   src_word = aligned;
        endcase
    end
endmodule

// File: rtl/rop_bool_unit.sv
module rop_bool_unit #(
    parameter int WORD_W = 16,
    parameter int CODE_W = 4
) (
    input  logic [WORD_W-1:0] s_word,
    input  logic [WORD_W-1:0] d_word,
    input  logic [CODE_W-1:0] code,
    input  logic              enable,
    output logic [WORD_W-1:0] result
);
    // Code bit index per pixel: {~S, ~D}; bit 0 is the S=1,D=1 entry.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        logic [1:0] idx;
        assign idx       = {~s_word[b], ~d_word[b]};
        assign result[b] = enable ? code[idx] : s_word[b];
    end
endmodule

// File: rtl/rop_shift_merge.sv
module rop_shift_merge
    import rop_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int CODE_W    = 4,
    parameter int PLANES    = 4,
    parameter int PLANE_IDX = 0,
    parameter int CTL_W     = 8,
    localparam int ROP_W    = CODE_W * PLANES,
    localparam int AMT_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_prime,
    input  logic [WORD_W-1:0] in_src,
    input  logic [WORD_W-1:0] in_dst,
    input  logic [ROP_W-1:0]  in_rop,
    input  logic [CTL_W-1:0]  in_mode_shift,
    input  logic [1:0]        in_src_sel,
    input  logic              in_rop_en,
    input  logic [WORD_W-1:0] in_wmask,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [WORD_W-1:0] out_strobe
);
    pipe_state_t       state_q, state_d;
    logic [WORD_W-1:0] prev_q;
    logic [WORD_W-1:0] src_word;
    logic [WORD_W-1:0] rop_word;
    logic [WORD_W-1:0] merged;
    logic [CODE_W-1:0] code;
    logic              accept;
    logic              take_word;
    logic              blit_en;

    assign in_ready  = (state_q == PS_IDLE) || out_ready;
    assign out_valid = (state_q == PS_HOLD);
    assign accept    = in_valid && in_ready;
    assign take_word = accept && !in_prime;
    assign blit_en   = (in_mode_shift[CTL_W-1 -: 3] == MODE_BLIT);

    if (PLANE_IDX < PLANES) begin : g_code
        assign code = in_rop[PLANE_IDX*CODE_W +: CODE_W];
    end else begin : g_code_def
        assign code = in_rop[CODE_W-1:0];
    end

    rop_src_path #(.WORD_W(WORD_W)) u_src (
        .prev_word (prev_q),
        .cur_word  (in_src),
        .blit_en   (blit_en),
        .amount    (in_mode_shift[AMT_W-1:0]),
        .sel       (in_src_sel),
        .src_word  (src_word)
    );

    rop_bool_unit #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_bool (
        .s_word (src_word),
        .d_word (in_dst),
        .code   (code),
        .enable (in_rop_en),
        .result (rop_word)
    );

    assign merged = (in_wmask & in_dst) | (~in_wmask & rop_word);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (take_word) state_d = PS_HOLD;
            PS_HOLD: if (out_ready && !take_word) state_d = PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= '0;
            out_data   <= '0;
            out_strobe <= '0;
        end else begin
            if (accept) prev_q <= in_src;
            if (take_word) begin
                out_data   <= merged;
                out_strobe <= ~in_wmask;
            end
        end
    end
endmodule

// File: rtl/rop_shift_merge_chk.sv
module rop_shift_merge_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         in_prime,
    input logic [W-1:0] in_dst,
    input logic [1:0]   in_src_sel,
    input logic         in_rop_en,
    input logic [W-1:0] in_wmask,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_data,
    input logic [W-1:0] out_strobe
);
    logic take;
    assign take = in_valid && in_ready && !in_prime;

    assert_reset_idle_R1: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid);

    assert_plain_source_R4: assert property (@(posedge clk) disable iff (rst)
        take && !in_rop_en && in_src_sel == 2'b00 && in_wmask == '0 |=> out_data == '1);

    assert_prime_silent_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_prime |=> !out_valid);

    assert_mask_keep_R10: assert property (@(posedge clk) disable iff (rst)
        take |=> ((out_data ^ $past(in_dst)) & $past(in_wmask)) == '0);

    assert_strobe_inv_R10: assert property (@(posedge clk) disable iff (rst)
        take |=> out_strobe == ~$past(in_wmask));

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_strobe));

    assert_ready_free_R11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);
endmodule

bind rop_shift_merge rop_shift_merge_chk #(.W(WORD_W)) u_chk (.*);

// File: tb/rop_shift_merge_test.sv
module rop_shift_merge_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0, in_prime = 0, in_rop_en = 0, out_ready = 1;
    logic [15:0] in_src = 0, in_dst = 0, in_rop = 0, in_wmask = 0;
    logic [7:0]  in_mode_shift = 0;
    logic [1:0]  in_src_sel = 0;
    logic        in_ready, out_valid;
    logic [15:0] out_data, out_strobe;

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    stall_on = 0;
    bit    done = 0;

    logic        m_valid = 0;
    logic [15:0] m_prev = 0, m_data = 0, m_strobe = 0;

    rop_shift_merge uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model_out(input logic [15:0] pw, s, d, r,
            input logic [7:0] ms, input logic [1:0] sel, input logic en, input logic [15:0] m);
        logic [31:0] cat;
        logic [15:0] pl, sv, res;
        cat = {pw, s} >> ms[3:0];
        pl  = (ms[7:5] == 3'b100) ? cat[15:0] : s;
        if (sel == 2'b00)      sv = 16'hFFFF;
        else if (sel == 2'b01) sv = s[0] ? 16'hFFFF : 16'h0000;
        else                   sv = pl;
        case (r[3:0])
            4'h0: res = 16'h0000;     4'h1: res = sv & d;
            4'h2: res = sv & ~d;      4'h3: res = sv;
            4'h4: res = ~sv & d;      4'h5: res = d;
            4'h6: res = sv ^ d;       4'h7: res = sv | d;
            4'h8: res = ~(sv | d);    4'h9: res = ~(sv ^ d);
            4'hA: res = ~d;           4'hB: res = sv | ~d;
            4'hC: res = ~sv;          4'hD: res = ~sv | d;
            4'hE: res = ~(sv & d);    default: res = 16'hFFFF;
        endcase
        if (!en) res = sv;
        return (m & d) | (~m & res);
    endfunction

    always @(posedge clk) begin
        logic rdy;
        if (rst) begin
            m_valid <= 0;
            m_prev  <= 0;
        end else begin
            rdy = !m_valid || out_ready;
            if (in_valid && rdy) begin
                m_prev <= in_src;
                if (!in_prime) begin
                    m_valid  <= 1;
                    m_data   <= model_out(m_prev, in_src, in_dst, in_rop, in_mode_shift,
                                          in_src_sel, in_rop_en, in_wmask);
                    m_strobe <= ~in_wmask;
                end else if (out_ready) m_valid <= 0;
            end else if (out_ready) m_valid <= 0;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            chk({cur_req, " out_valid"}, {15'd0, out_valid}, {15'd0, m_valid});
            chk({cur_req, " in_ready R11"}, {15'd0, in_ready}, {15'd0, (!m_valid || out_ready)});
            if (m_valid) begin
                chk({cur_req, " out_data"}, out_data, m_data);
                chk({cur_req, " out_strobe R10"}, out_strobe, m_strobe);
            end
        end
    end

    always @(negedge clk) out_ready <= stall_on ? 1'($urandom % 2) : 1'b1;

    task automatic send(input logic [15:0] s, d, r, input logic [7:0] ms,
            input logic [1:0] sel, input logic en, input logic [15:0] m, input logic pr);
        @(negedge clk);
        in_valid = 1; in_src = s; in_dst = d; in_rop = r; in_mode_shift = ms;
        in_src_sel = sel; in_rop_en = en; in_wmask = m; in_prime = pr;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic xfer(input logic [15:0] s, d, r, input logic [7:0] ms,
            input logic [1:0] sel, input logic en, input logic [15:0] m,
            output logic [15:0] res);
        send(s, d, r, ms, sel, en, m, 1'b0);
        @(negedge clk);
        in_valid = 0;
        #2;
        res = out_data;
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk("R1 out_valid after reset", {15'd0, out_valid}, 16'd0);
        // R1: previous word is zero, blit shift 4
        xfer(16'hABCD, 16'h0, 16'h0003, 8'h84, 2'b11, 1, 16'h0, r);
        chk("R1 zero prev word", r, 16'h0ABC);

        cur_req = "R2";
        for (int c = 0; c < 16; c++) begin
            xfer(16'hAAAA, 16'hCCCC, 16'(c), 8'hE0, 2'b11, 1, 16'h0, r);
            if (c == 6)  chk("R2 xor", r, 16'h6666);
            if (c == 8)  chk("R2 nor", r, 16'h1111);
            if (c == 11) chk("R2 s or not d", r, 16'hBBBB);
        end

        cur_req = "R3";
        xfer(16'h1234, 16'hFFFF, 16'h5A63, 8'hE0, 2'b11, 1, 16'h0, r);
        chk("R3 upper nibbles ignored", r, 16'h1234);
        xfer(16'h1234, 16'hFFFF, 16'h3330, 8'hE0, 2'b11, 1, 16'h0, r);
        chk("R3 low nibble zero", r, 16'h0000);

        cur_req = "R4";
        xfer(16'h5A5A, 16'h0F0F, 16'h0000, 8'hE0, 2'b11, 0, 16'h0, r);
        chk("R4 rop disabled", r, 16'h5A5A);

        cur_req = "R5";
        xfer(16'h1234, 16'h0, 16'h0003, 8'hE0, 2'b00, 1, 16'h0, r);
        chk("R5 all ones", r, 16'hFFFF);
        xfer(16'h0001, 16'h0, 16'h0003, 8'hE0, 2'b01, 1, 16'h0, r);
        chk("R5 replicate one", r, 16'hFFFF);
        xfer(16'hFFFE, 16'h0, 16'h0003, 8'hE0, 2'b01, 1, 16'h0, r);
        chk("R5 replicate zero", r, 16'h0000);
        xfer(16'h8421, 16'h0, 16'h0003, 8'hE0, 2'b10, 1, 16'h0, r);
        chk("R5 alt plane", r, 16'h8421);

        cur_req = "R6";
        xfer(16'h1234, 16'h0, 16'h0003, 8'hE0, 2'b11, 1, 16'h0, r);  // R8 normal load
        xfer(16'h5678, 16'h0, 16'h0003, 8'h88, 2'b11, 1, 16'h0, r);
        chk("R6 R8 shift 8", r, 16'h3456);
        xfer(16'h9ABC, 16'h0, 16'h0003, 8'h98, 2'b11, 1, 16'h0, r);
        chk("R6 shift bit4 ignored", r, 16'h789A);
        xfer(16'h4321, 16'h0, 16'h0003, 8'h80, 2'b11, 1, 16'h0, r);
        chk("R6 shift 0", r, 16'h4321);

        cur_req = "R7";
        xfer(16'hF00F, 16'h0, 16'h0003, 8'h47, 2'b11, 1, 16'h0, r);
        chk("R7 vector no shift", r, 16'hF00F);
        xfer(16'h0FF0, 16'h0, 16'h0003, 8'h07, 2'b11, 1, 16'h0, r);
        chk("R7 other mode no shift", r, 16'h0FF0);

        cur_req = "R9";
        send(16'hDEAD, 16'h0, 16'h0003, 8'hE0, 2'b11, 1, 16'h0, 1'b1);
        @(negedge clk);
        in_valid = 0;
        #2;
        chk("R9 prime no output", {15'd0, out_valid}, 16'd0);
        xfer(16'hBEEF, 16'h0, 16'h0003, 8'h8C, 2'b11, 1, 16'h0, r);
        chk("R9 R8 primed word used", r, 16'hEADB);

        cur_req = "R10";
        xfer(16'hFFFF, 16'h1234, 16'h0003, 8'hE0, 2'b11, 1, 16'hFF00, r);
        chk("R10 masked merge", r, 16'h12FF);
        chk("R10 strobe", out_strobe, 16'h00FF);

        cur_req = "R11";
        stall_on = 1;
        for (int i = 0; i < 600; i++) begin
            logic [7:0] ms;
            ms = {3'($urandom % 8), 5'($urandom)};
            if ($urandom % 3 == 0) ms[7:5] = 3'b100;
            send(16'($urandom), 16'($urandom), 16'($urandom), ms, 2'($urandom),
                 1'($urandom), 16'($urandom), 1'($urandom % 5 == 0));
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                in_valid = 0;
            end
        end
        @(negedge clk);
        in_valid = 0;
        stall_on = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        #2;
        finish_run();
    end
endmodule